// File: doc/BRIEF.md
# Timer capture and compare unit

This unit watches a free-running 16-bit timer owned by another block. It works in one of two ways. In capture mode, selected edges on an external pin copy the timer value into the unit's 16-bit register and raise an interrupt strobe. In compare mode, the unit checks the timer against that same register every cycle. When the two are equal it drives its pin, raises the interrupt strobe, or asks the timer owner to restart the count and asks the converter to begin a conversion.

A single 4-bit mode input selects the behaviour. Capture can happen on every rising edge, on every falling edge, on every 4th rising edge or on every 16th rising edge. Compare can toggle the pin, set or clear the pin after a defined starting level, raise the interrupt only, or act as a special-event trigger. The capture pin crosses a two-stage synchronizer before edge detection.

All event outputs are single-cycle strobes from flops. The timer, the interrupt controller and the converter are outside this unit.

Top module: `ccu_unit`

## Requirements
- R1: After reset, and in modes 0000 and 0001, all of the following are 0: `irq_o`, `tmr_rst_o`, `adc_start_o`, `cmp_pin_o` and `cmp_oe_o`. In these modes the edge prescaler, the match history and the pin state are all cleared. After reset, `reg_o` is 0.
- R2: Modes 0101 and 0011 capture on rising edges of `cap_pin_i`. Mode 0100 captures on falling edges. A capture loads `timer_i` into `reg_o` and pulses `irq_o` for one cycle. Both become visible after the third rising clock edge following the pin change. An edge of the opposite polarity does nothing.
- R3: Mode 0110 captures on every 4th qualifying rising edge. Mode 0111 captures on every 16th. The rising edges in between change neither `reg_o` nor `irq_o`.
- R4: Any change of `mode_i` clears the edge prescaler. The first capture after a change therefore needs a full 4 or 16 rising edges.
- R5: When a capture and a `reg_wr_i` write fall in the same cycle, the captured timer value wins.
- R6: In a compare mode, a match event fires in the first cycle where `timer_i` equals `reg_o`. It does not repeat while that equality holds. No match event fires in a cycle in which `mode_i` differs from its value in the previous cycle. Event strobes appear after the clock edge that ends the match cycle.
- R7: Mode 0010 toggles `cmp_pin_o` on each match and pulses `irq_o`. On entry, the pin starts at 0 and `cmp_oe_o` is 1.
- R8: Mode 1000 starts the pin at 0 and sets it on a match. Mode 1001 starts the pin at 1 and clears it on a match. Both pulse `irq_o` on a match, hold `cmp_oe_o` at 1, and keep the pin level until the mode changes.
- R9: Mode 1010 pulses only `irq_o` on a match. `cmp_oe_o` and `cmp_pin_o` stay 0.
- R10: Mode 1011 pulses `irq_o` and `tmr_rst_o` on a match, and pulses `adc_start_o` only when `conv_en_i` is 1. With parameter `SPECIAL_EVT_EN` = 0, mode 1011 behaves exactly like mode 1010.
- R11: Modes 1100 to 1111 leave the unit idle. No capture, no event, and pin and enable both at 0.
- R12: `reg_wr_i` loads `reg_wdata_i` into the register at the clock edge, and `reg_o` always shows the register. A match in the same cycle is judged against the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Mode select |
| timer_i | input | 16 | Current timer count |
| cap_pin_i | input | 1 | External capture pin, asynchronous |
| conv_en_i | input | 1 | Converter start allowed |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_o | output | 16 | Compare/capture register |
| cmp_pin_o | output | 1 | Compare pin drive level |
| cmp_oe_o | output | 1 | Compare pin output enable |
| irq_o | output | 1 | Interrupt flag strobe |
| tmr_rst_o | output | 1 | Timer restart strobe |
| adc_start_o | output | 1 | Conversion start strobe |

## Verification
A software write to the register can land in the same cycle in which a synchronized capture edge loads the timer. The bench arranges this by counting clock edges from the pin change and asserting the write in the exact cycle where the capture is detected. It then expects the timer value, not the write data, together with the interrupt strobe. A second overlap is a write paired with a compare in the same cycle. Here the bench expects no event, because the old register value is compared, and then expects a match event in the following cycle against the new value.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [1:0] {
    PIN_NONE,
    PIN_SET,
    PIN_CLR,
    PIN_TGL
  } pin_act_e;

  typedef enum logic [1:0] {
    DIV_ONE,
    DIV_MID,
    DIV_HI
  } cap_div_e;

  typedef struct packed {
    logic     cap_en;
    logic     cap_fall;
    cap_div_e cap_div;
    logic     cmp_en;
    logic     pin_drv;
    logic     pin_init;
    pin_act_e pin_act;
    logic     spec_evt;
  } mode_dec_t;

endpackage

// File: rtl/ccu_mode_dec.sv
module ccu_mode_dec
  import ccu_pkg::*;
#(
  parameter bit SPECIAL_EVT_EN = 1'b1
) (
  input  logic [3:0] mode_i,
  output mode_dec_t  dec_o
);

  always_comb begin
    dec_o = '0;
    unique case (mode_i)
      4'b0010: begin
        dec_o.cmp_en  = 1'b1;
        dec_o.pin_drv = 1'b1;
        dec_o.pin_act = PIN_TGL;
      end
      4'b0011, 4'b0101: dec_o.cap_en = 1'b1;
      4'b0100: begin
        dec_o.cap_en   = 1'b1;
        dec_o.cap_fall = 1'b1;
      end
      4'b0110: begin
        dec_o.cap_en  = 1'b1;
        dec_o.cap_div = DIV_MID;
      end
      4'b0111: begin
        dec_o.cap_en  = 1'b1;
        dec_o.cap_div = DIV_HI;
      end
      4'b1000: begin
        dec_o.cmp_en  = 1'b1;
        dec_o.pin_drv = 1'b1;
        dec_o.pin_act = PIN_SET;
      end
      4'b1001: begin
        dec_o.cmp_en   = 1'b1;
        dec_o.pin_drv  = 1'b1;
        dec_o.pin_init = 1'b1;
        dec_o.pin_act  = PIN_CLR;
      end
      4'b1010: dec_o.cmp_en = 1'b1;
      4'b1011: begin
        dec_o.cmp_en   = 1'b1;
        dec_o.spec_evt = SPECIAL_EVT_EN;
      end
      default: dec_o = '0; // off, reserved, pwm
    endcase
  end

endmodule

// File: rtl/ccu_capture.sv
module ccu_capture
  import ccu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_MID_N   = 4,
  parameter int unsigned DIV_HI_N    = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_i,
  input  logic     en_i,
  input  logic     fall_i,
  input  cap_div_e div_i,
  input  logic     clr_i,
  output logic     cap_o
);

  localparam int unsigned CNT_W = (DIV_HI_N > 2) ? $clog2(DIV_HI_N) : 1;

  logic [SYNC_STAGES:0] sync_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     lim;
  logic                 rise, fall, qual;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], pin_i};
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];
  assign qual = en_i & (fall_i ? fall : rise);

  always_comb begin
    unique case (div_i)
      DIV_MID: lim = CNT_W'(DIV_MID_N - 1);
      DIV_HI:  lim = CNT_W'(DIV_HI_N - 1);
      default: lim = '0;
    endcase
  end

  assign cap_o = qual & ~clr_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || !en_i)     cnt_q <= '0;
    else if (qual) begin
      if (cnt_q == lim) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/ccu_compare.sv
module ccu_compare
  import ccu_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] cmp_val_i,
  input  logic          en_i,
  input  logic          chg_i,
  input  logic          pin_drv_i,
  input  logic          pin_init_i,
  input  pin_act_e      pin_act_i,
  output logic          hit_o,
  output logic          pin_o
);

  logic eq, eq_q, pin_q;

  assign eq    = (timer_i == cmp_val_i);
  assign hit_o = en_i & ~chg_i & eq & ~eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= en_i & eq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pin_q <= 1'b0;
    else if (!pin_drv_i) pin_q <= 1'b0;
    else if (chg_i)      pin_q <= pin_init_i;
    else if (hit_o) begin
      unique case (pin_act_i)
        PIN_SET: pin_q <= 1'b1;
        PIN_CLR: pin_q <= 1'b0;
        PIN_TGL: pin_q <= ~pin_q;
        default: pin_q <= pin_q;
      endcase
    end
  end

  assign pin_o = pin_q;

endmodule

// File: rtl/ccu_unit.sv
module ccu_unit
  import ccu_pkg::*;
#(
  parameter int unsigned TW             = 16,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned DIV_MID_N      = 4,
  parameter int unsigned DIV_HI_N       = 16,
  parameter bit          SPECIAL_EVT_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    mode_i,
  input  logic [TW-1:0] timer_i,
  input  logic          cap_pin_i,
  input  logic          conv_en_i,
  input  logic          reg_wr_i,
  input  logic [TW-1:0] reg_wdata_i,
  output logic [TW-1:0] reg_o,
  output logic          cmp_pin_o,
  output logic          cmp_oe_o,
  output logic          irq_o,
  output logic          tmr_rst_o,
  output logic          adc_start_o
);

  mode_dec_t     dec;
  logic [3:0]    mode_q;
  logic          mode_chg, cap, hit;
  logic [TW-1:0] reg_q;
  logic          irq_q, trst_q, adc_q;

  ccu_mode_dec #(.SPECIAL_EVT_EN(SPECIAL_EVT_EN)) i_dec (
    .mode_i (mode_i),
    .dec_o  (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else         mode_q <= mode_i;
  end

  assign mode_chg = (mode_i != mode_q);

  ccu_capture #(
    .SYNC_STAGES (SYNC_STAGES),
    .DIV_MID_N   (DIV_MID_N),
    .DIV_HI_N    (DIV_HI_N)
  ) i_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .en_i   (dec.cap_en),
    .fall_i (dec.cap_fall),
    .div_i  (dec.cap_div),
    .clr_i  (mode_chg),
    .cap_o  (cap)
  );

  ccu_compare #(.TW(TW)) i_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .timer_i    (timer_i),
    .cmp_val_i  (reg_q),
    .en_i       (dec.cmp_en),
    .chg_i      (mode_chg),
    .pin_drv_i  (dec.pin_drv),
    .pin_init_i (dec.pin_init),
    .pin_act_i  (dec.pin_act),
    .hit_o      (hit),
    .pin_o      (cmp_pin_o)
  );

  // capture has priority over a software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       reg_q <= '0;
    else if (cap)      reg_q <= timer_i;
    else if (reg_wr_i) reg_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      trst_q <= 1'b0;
      adc_q  <= 1'b0;
    end else begin
      irq_q  <= cap | hit;
      trst_q <= hit & dec.spec_evt;
      adc_q  <= hit & dec.spec_evt & conv_en_i;
    end
  end

  assign reg_o       = reg_q;
  assign cmp_oe_o    = dec.pin_drv;
  assign irq_o       = irq_q;
  assign tmr_rst_o   = trst_q;
  assign adc_start_o = adc_q;

endmodule

// File: rtl/ccu_unit_chk.sv
module ccu_unit_chk #(
  parameter int unsigned TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    mode_i,
  input logic [TW-1:0] timer_i,
  input logic          reg_wr_i,
  input logic [TW-1:0] reg_o,
  input logic          cmp_pin_o,
  input logic          irq_o,
  input logic          tmr_rst_o,
  input logic          adc_start_o
);

  logic cmp_mode;
  assign cmp_mode = (mode_i == 4'b0010) || (mode_i[3:2] == 2'b10);

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {4'b0000, 4'b0001}) |=>
      (!irq_o && !tmr_rst_o && !adc_start_o && !cmp_pin_o));

  p_reg_change_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_o != $past(reg_o)) && !$past(reg_wr_i)) |-> irq_o);

  p_no_repeat_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && cmp_mode && $stable(mode_i) && $stable(timer_i) && $stable(reg_o))
      |=> !irq_o);

  p_trst_with_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_rst_o |-> irq_o);

  p_adc_with_trst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> tmr_rst_o);

  p_trst_mode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_rst_o |-> ($past(mode_i) == 4'b1011));

  p_pwm_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[3:2] == 2'b11) |=>
      (!irq_o && !tmr_rst_o && !adc_start_o && !cmp_pin_o));

endmodule

bind ccu_unit ccu_unit_chk #(.TW(TW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .timer_i     (timer_i),
  .reg_wr_i    (reg_wr_i),
  .reg_o       (reg_o),
  .cmp_pin_o   (cmp_pin_o),
  .irq_o       (irq_o),
  .tmr_rst_o   (tmr_rst_o),
  .adc_start_o (adc_start_o)
);

// File: tb/test_ccu_unit.sv
module test_ccu_unit;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 22;

  typedef struct packed {
    logic [3:0]  mode;
    logic        wr;
    logic [15:0] wdata;
    logic [15:0] timer;
    logic        pin;
    logic        oe;
    logic        irq;
    logic        trst;
    logic        adc;
    logic [3:0]  req;
  } vec_t;

  // one vector per clock; outputs judged after that clock's edge
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 1'b1, 16'h0100, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 load
    '{4'b0010, 1'b0, 16'h0000, 16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 entry cycle
    '{4'b0010, 1'b0, 16'h0000, 16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 held equality
    '{4'b0010, 1'b0, 16'h0000, 16'h0101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{4'b0010, 1'b0, 16'h0000, 16'h0100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 toggle
    '{4'b0010, 1'b0, 16'h0000, 16'h00FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
    '{4'b0010, 1'b0, 16'h0000, 16'h0100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 toggle back
    '{4'b1000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 init low
    '{4'b1000, 1'b0, 16'h0000, 16'h0100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 set
    '{4'b1000, 1'b0, 16'h0000, 16'h0200, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 hold
    '{4'b1001, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 init high
    '{4'b1001, 1'b0, 16'h0000, 16'h0100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 clear
    '{4'b1010, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9
    '{4'b1010, 1'b0, 16'h0000, 16'h0100, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd9},  // R9 flag only
    '{4'b1011, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{4'b1011, 1'b0, 16'h0000, 16'h0100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd10}, // R10 special
    '{4'b1011, 1'b1, 16'h0200, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 old value
    '{4'b1011, 1'b0, 16'h0000, 16'h0200, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd12}, // R12 new value
    '{4'b1100, 1'b0, 16'h0000, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{4'b1111, 1'b0, 16'h0000, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{4'b0001, 1'b0, 16'h0000, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1},  // R1 reserved
    '{4'b0000, 1'b0, 16'h0000, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1}   // R1 off
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] timer = '0;
  logic        cap_pin = 1'b0;
  logic        conv_en = 1'b1;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;

  logic [15:0] reg_a, reg_b;
  logic        pin_a, oe_a, irq_a, trst_a, adc_a;
  logic        pin_b, oe_b, irq_b, trst_b, adc_b;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccu_unit i_ccu_unit (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .timer_i(timer),
    .cap_pin_i(cap_pin), .conv_en_i(conv_en), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_o(reg_a), .cmp_pin_o(pin_a),
    .cmp_oe_o(oe_a), .irq_o(irq_a), .tmr_rst_o(trst_a), .adc_start_o(adc_a)
  );

  ccu_unit #(.SPECIAL_EVT_EN(1'b0)) i_ccu_unit_noevt (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .timer_i(timer),
    .cap_pin_i(cap_pin), .conv_en_i(conv_en), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_o(reg_b), .cmp_pin_o(pin_b),
    .cmp_oe_o(oe_b), .irq_o(irq_b), .tmr_rst_o(trst_b), .adc_start_o(adc_b)
  );

  always @(posedge clk) if (rst_n && irq_a) irq_cnt++;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse();
    cap_pin = 1'b1;
    repeat (4) step();
    cap_pin = 1'b0;
    repeat (4) step();
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode = m;
    repeat (2) step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1", "reset outs", {27'd0, pin_a, oe_a, irq_a, trst_a, adc_a}, 32'd0);
    chk("R1", "reset reg", {16'd0, reg_a}, 32'd0);

    // compare vector table
    for (int i = 0; i < NV; i++) begin
      mode = VECS[i].mode;
      reg_wr = VECS[i].wr;
      reg_wdata = VECS[i].wdata;
      timer = VECS[i].timer;
      step();
      reg_wr = 1'b0;
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec%0d", i),
          {27'd0, pin_a, oe_a, irq_a, trst_a, adc_a},
          {27'd0, VECS[i].pin, VECS[i].oe, VECS[i].irq, VECS[i].trst, VECS[i].adc});
      // R10 variant without special event: same flag, no strobes
      chk("R10", $sformatf("noevt vec%0d", i),
          {29'd0, irq_b, trst_b, adc_b}, {29'd0, VECS[i].irq, 2'b00});
    end

    // R10 converter disabled
    mode = 4'b1011; reg_wr = 1'b1; reg_wdata = 16'h0300; timer = 16'h0000;
    step();
    reg_wr = 1'b0; timer = 16'h0300; conv_en = 1'b0;
    step();
    chk("R10", "conv off", {29'd0, irq_a, trst_a, adc_a}, 32'b110);
    conv_en = 1'b1;

    // R2 exact latency, rising
    set_mode(4'b0000);
    timer = 16'h1234;
    set_mode(4'b0101);
    cap_pin = 1'b1;
    step(); step();
    chk("R2", "early irq", {31'd0, irq_a}, 32'd0);
    step();
    chk("R2", "rise irq", {31'd0, irq_a}, 32'd1);
    chk("R2", "rise reg", {16'd0, reg_a}, 32'h1234);
    step();
    chk("R2", "irq one cycle", {31'd0, irq_a}, 32'd0);
    timer = 16'h2222;
    cap_pin = 1'b0;
    repeat (4) step();
    chk("R2", "fall ignored", {16'd0, reg_a}, 32'h1234);

    // R2 falling mode
    set_mode(4'b0100);
    cap_pin = 1'b1;
    repeat (4) step();
    chk("R2", "rise ignored", {16'd0, reg_a}, 32'h1234);
    timer = 16'h3333;
    cap_pin = 1'b0;
    repeat (4) step();
    chk("R2", "fall capture", {16'd0, reg_a}, 32'h3333);

    // R2 mode 0011
    set_mode(4'b0011);
    timer = 16'h4444;
    pulse();
    chk("R2", "mode3 capture", {16'd0, reg_a}, 32'h4444);

    // R3 divide by 4
    set_mode(4'b0110);
    c0 = irq_cnt;
    for (int i = 0; i < 3; i++) begin timer = 16'h5000 + 16'(i); pulse(); end
    chk("R3", "div4 held", {16'd0, reg_a}, 32'h4444);
    timer = 16'h5003; pulse();
    chk("R3", "div4 capture", {16'd0, reg_a}, 32'h5003);
    for (int i = 0; i < 4; i++) begin timer = 16'h6000 + 16'(i); pulse(); end
    chk("R3", "div4 second", {16'd0, reg_a}, 32'h6003);
    chk("R3", "div4 irq count", irq_cnt - c0, 32'd2);

    // R3 divide by 16
    set_mode(4'b0111);
    c0 = irq_cnt;
    for (int i = 0; i < 15; i++) begin timer = 16'h7000 + 16'(i); pulse(); end
    chk("R3", "div16 held", {16'd0, reg_a}, 32'h6003);
    timer = 16'h700F; pulse();
    chk("R3", "div16 capture", {16'd0, reg_a}, 32'h700F);
    chk("R3", "div16 irq count", irq_cnt - c0, 32'd1);

    // R4 mode change clears prescaler
    set_mode(4'b0110);
    for (int i = 0; i < 2; i++) begin timer = 16'h8000 + 16'(i); pulse(); end
    set_mode(4'b0111);
    set_mode(4'b0110);
    for (int i = 0; i < 3; i++) begin timer = 16'h9000 + 16'(i); pulse(); end
    chk("R4", "count restarted", {16'd0, reg_a}, 32'h700F);
    timer = 16'h9003; pulse();
    chk("R4", "full count", {16'd0, reg_a}, 32'h9003);

    // R5 capture wins over write
    set_mode(4'b0101);
    timer = 16'hA5A5;
    cap_pin = 1'b1;
    step(); step();
    reg_wr = 1'b1; reg_wdata = 16'hBEEF;
    step();
    reg_wr = 1'b0;
    chk("R5", "collision reg", {16'd0, reg_a}, 32'hA5A5);
    chk("R5", "collision irq", {31'd0, irq_a}, 32'd1);
    step();
    reg_wr = 1'b1; reg_wdata = 16'hBEEF;
    step();
    reg_wr = 1'b0;
    chk("R12", "plain write", {16'd0, reg_a}, 32'hBEEF);
    cap_pin = 1'b0;
    repeat (4) step();

    // R11 pwm ignores capture pin
    set_mode(4'b1100);
    c0 = irq_cnt;
    timer = 16'h1111;
    pulse();
    chk("R11", "pwm reg", {16'd0, reg_a}, 32'hBEEF);
    chk("R11", "pwm irq", irq_cnt - c0, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule